// File: doc/BRIEF.md
# Paged Shadow Memory Controller for Calibration Storage

This block keeps a 128-byte non-volatile store and a 128-byte working SRAM behind a byte-wide register bus. The SRAM is divided into four 32-byte pages. Software picks one page with a two-bit field in a control register. That page then shows up in a fixed 32-byte window of the register map. The non-volatile store cannot be read directly. Its contents reach the bus only by being copied into the SRAM.

Three maintenance operations are started from the same control register. Each one starts when its command bit is written to one and then back to zero. A copy moves the whole non-volatile store into the SRAM in a single cycle. The same copy also runs each time the active input rises. An erase clears one page in both memories. A program merges the whole SRAM into the non-volatile store. Erase and program each take a long, parameterised number of cycles, and a status bit shows that the operation is still running. Both are refused unless the power and boost-converter interlock inputs show a safe state.

Window accesses can use an auto-incrementing offset pointer, so a full page can be moved as one burst. The window is blocked while the lighting sequencer runs on its own.

Top module: `nvm_shadow_ctrl`

## Requirements
- R1: After reset, the control register (address 0DH) reads 00H and every SRAM byte reads 00H.
- R2: A read or write strobe is sampled on a clock edge, and read data is valid from that edge onward. The control register reads as {bit7 busy, bits6:5 zero, bit4 program, bit3 erase, bit2 load, bits1:0 page}. Window address 40H+o (o in 0..31) reaches SRAM byte page*32+o.
- R3: An access with the increment input high ignores the address and uses the window offset held in a pointer. Each window access that is carried out sets the pointer to its own offset plus one, and the offset wraps from 31 to 0 inside the same page.
- R4: While the sequencer input is high, window writes change nothing, window reads return 00H and the pointer keeps its value.
- R5: Writing the load bit (bit2) from 1 to 0, or a rising edge on the active input, copies the whole non-volatile store into the SRAM, provided no erase or program is running.
- R6: An accepted erase sets the selected 32-byte page to 00H in both memories and leaves the other pages unchanged.
- R7: An accepted program sets every non-volatile byte to the bitwise OR of its old value and the SRAM byte at the same position.
- R8: Erase and program start only if, at the clearing write, the active input is 1, the boost-enable input is 0 and the boost level equals 12H. A refused request leaves both memories unchanged and never sets busy.
- R9: A control write that sets both bit3 and bit4 leaves both bits at their previous values and starts nothing.
- R10: Busy reads 1 from the cycle after the accepted clearing write. It reads 0 once OP_CYCLES+1 clock edges have passed since the write that raised the command bit.
- R11: While busy, window writes are ignored, command handshakes start nothing, and window reads still work.
- R12: An erase acts on the page in the page field of the clearing write, even if the page field is changed before the erase finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| active_i | input | 1 | High when the device is out of standby |
| boost_on_i | input | 1 | Boost converter enable, must be low for erase or program |
| boost_level_i | input | 8 | Boost output setting, must equal 12H for erase or program |
| auto_seq_i | input | 1 | Automatic sequencing running, which blocks the window |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_incr_i | input | 1 | Use the auto-increment window pointer instead of the address |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, registered |

## Verification
The assertions check on every cycle that window writes never reach the SRAM while busy or while the sequencer runs, that a copy never happens during a long operation, that busy rises only after a cycle in which the interlock held, and that busy falls only when an operation completes. Bit-accurate contents need the bench's scenarios and its memory model: page mapping, pointer wrap, the OR merge on program, which page an erase clears after the page field changes, and the exact cycle on which busy clears.

// File: rtl/nvm_shadow_pkg.sv
`timescale 1ns/1ps
package nvm_shadow_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_ERASE = 2'd1,
      OP_PROG  = 2'd2
   } nvm_op_e;

   // command bit positions inside the control register
   localparam int LOAD_BIT  = 2;
   localparam int ERASE_BIT = 3;
   localparam int PROG_BIT  = 4;
endpackage

// File: rtl/nvm_cmd_ctrl.sv
`timescale 1ns/1ps
module nvm_cmd_ctrl
   import nvm_shadow_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PAGE_W    = 2,
   parameter int OP_CYCLES = 20_000_000,
   parameter logic [DATA_W-1:0] BOOST_CODE = 8'h12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              boost_on_i,
   input  logic [DATA_W-1:0] boost_level_i,
   input  logic              ctl_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [PAGE_W-1:0] page_o,
   output logic              busy_o,
   output logic              load_o,
   output logic              erase_o,
   output logic [PAGE_W-1:0] erase_page_o,
   output logic              prog_o,
   output logic [DATA_W-1:0] ctrl_rd_o
);
   localparam int TMR_W = $clog2(OP_CYCLES + 1);
   localparam logic [TMR_W-1:0] TMR_END = TMR_W'(OP_CYCLES);

   if (OP_CYCLES < 1) begin : g_bad_cycles
      $error("OP_CYCLES must be at least 1");
   end
   if (PAGE_W > LOAD_BIT) begin : g_bad_pagew
      $error("page field overlaps the command bits");
   end
   if (PROG_BIT >= DATA_W - 1) begin : g_bad_dataw
      $error("data width too small for the control layout");
   end

   logic [PAGE_W-1:0] page_q, op_page_q;
   logic              load_q, erase_q, prog_q;
   logic              busy_q, armed_q, act_d_q;
   nvm_op_e           op_q;
   logic [TMR_W-1:0]  tmr_q;

   logic both_set, erase_nxt, prog_nxt;
   logic rise_any, fall_e, fall_p, load_fall;
   logic interlock_ok, arm, start_e, start_p, done;
   logic unused_wdata;

   assign unused_wdata = ^wdata_i;

   // a write that sets both long-operation bits keeps both unchanged
   assign both_set  = wdata_i[ERASE_BIT] & wdata_i[PROG_BIT];
   assign erase_nxt = both_set ? erase_q : wdata_i[ERASE_BIT];
   assign prog_nxt  = both_set ? prog_q  : wdata_i[PROG_BIT];

   assign rise_any  = ctl_wr_i && ((!erase_q && erase_nxt) || (!prog_q && prog_nxt));
   assign fall_e    = ctl_wr_i && erase_q && !erase_nxt;
   assign fall_p    = ctl_wr_i && prog_q && !prog_nxt;
   assign load_fall = ctl_wr_i && load_q && !wdata_i[LOAD_BIT];

   assign interlock_ok = active_i && !boost_on_i && (boost_level_i == BOOST_CODE);

   assign arm     = rise_any && !busy_q;
   assign start_e = fall_e && armed_q && !busy_q && interlock_ok;
   assign start_p = fall_p && armed_q && !busy_q && interlock_ok;
   assign done    = busy_q && (tmr_q == TMR_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q    <= '0;
         op_page_q <= '0;
         load_q    <= 1'b0;
         erase_q   <= 1'b0;
         prog_q    <= 1'b0;
         busy_q    <= 1'b0;
         armed_q   <= 1'b0;
         act_d_q   <= 1'b0;
         op_q      <= OP_IDLE;
         tmr_q     <= '0;
      end else begin
         act_d_q <= active_i;
         if (ctl_wr_i) begin
            page_q  <= wdata_i[PAGE_W-1:0];
            load_q  <= wdata_i[LOAD_BIT];
            erase_q <= erase_nxt;
            prog_q  <= prog_nxt;
         end
         if (arm) begin
            armed_q <= 1'b1;
            tmr_q   <= '0;
         end else begin
            if (fall_e || fall_p) armed_q <= 1'b0;
            if (tmr_q != TMR_END) tmr_q <= tmr_q + 1'b1;
         end
         if (start_e || start_p) begin
            busy_q    <= 1'b1;
            op_q      <= start_e ? OP_ERASE : OP_PROG;
            op_page_q <= wdata_i[PAGE_W-1:0];
         end else if (done) begin
            busy_q <= 1'b0;
            op_q   <= OP_IDLE;
         end
      end
   end

   assign page_o       = page_q;
   assign busy_o       = busy_q;
   assign load_o       = !busy_q && (load_fall || (active_i && !act_d_q));
   assign erase_o      = done && (op_q == OP_ERASE);
   assign prog_o       = done && (op_q == OP_PROG);
   assign erase_page_o = op_page_q;

   always_comb begin
      ctrl_rd_o                 = '0;
      ctrl_rd_o[PAGE_W-1:0]     = page_q;
      ctrl_rd_o[LOAD_BIT]       = load_q;
      ctrl_rd_o[ERASE_BIT]      = erase_q;
      ctrl_rd_o[PROG_BIT]       = prog_q;
      ctrl_rd_o[DATA_W-1]       = busy_q;
   end
endmodule

// File: rtl/nvm_win_port.sv
`timescale 1ns/1ps
module nvm_win_port #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int PAGE_W = 2,
   parameter int OFS_W  = 5,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0D,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 8'h40
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_i,
   input  logic                    rd_i,
   input  logic                    incr_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic                    auto_seq_i,
   input  logic                    busy_i,
   input  logic [PAGE_W-1:0]       page_i,
   input  logic [DATA_W-1:0]       ctrl_rd_i,
   input  logic [DATA_W-1:0]       sram_rd_i,
   output logic                    ctl_wr_o,
   output logic                    sram_we_o,
   output logic [PAGE_W+OFS_W-1:0] idx_o,
   output logic [DATA_W-1:0]       rdata_o
);
   localparam int TAG_W = ADDR_W - OFS_W;
   localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:OFS_W];

   if (TAG_W < 1) begin : g_bad_ofs
      $error("window offset wider than the address");
   end

   logic [OFS_W-1:0] ptr_q, ofs;
   logic in_win, win_ok, is_ctl, step;

   assign ofs    = incr_i ? ptr_q : addr_i[OFS_W-1:0];
   assign in_win = incr_i || (addr_i[ADDR_W-1:OFS_W] == WIN_TAG);
   assign is_ctl = !incr_i && (addr_i == CTRL_ADDR);
   assign win_ok = in_win && !auto_seq_i;

   assign sram_we_o = wr_i && win_ok && !busy_i;
   assign ctl_wr_o  = wr_i && is_ctl;
   assign step      = (rd_i && win_ok) || sram_we_o;
   assign idx_o     = {page_i, ofs};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         rdata_o <= '0;
      end else begin
         if (step) ptr_q <= ofs + 1'b1;
         if (rd_i) begin
            if (win_ok)      rdata_o <= sram_rd_i;
            else if (is_ctl) rdata_o <= ctrl_rd_i;
            else             rdata_o <= '0;
         end
      end
   end
endmodule

// File: rtl/nvm_dual_store.sv
`timescale 1ns/1ps
module nvm_dual_store #(
   parameter int DATA_W     = 8,
   parameter int PAGES      = 4,
   parameter int PAGE_BYTES = 32,
   parameter bit PROG_MERGE = 1'b1,
   parameter logic [DATA_W-1:0] NVM_RESET_VAL = '0,
   localparam int PAGE_W = $clog2(PAGES),
   localparam int OFS_W  = $clog2(PAGE_BYTES),
   localparam int IDX_W  = PAGE_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_all_i,
   input  logic              erase_i,
   input  logic [PAGE_W-1:0] erase_page_i,
   input  logic              prog_i,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int DEPTH = PAGES * PAGE_BYTES;

   logic [DEPTH*DATA_W-1:0] sram_flat;

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_byte
      localparam logic [PAGE_W-1:0] PG   = PAGE_W'(gi / PAGE_BYTES);
      localparam logic [IDX_W-1:0]  SLOT = IDX_W'(gi);

      logic [DATA_W-1:0] nvm_q, sram_q, prog_val;
      logic              wipe;

      assign wipe = erase_i && (erase_page_i == PG);

      if (PROG_MERGE) begin : g_merge
         // bits can only be set by programming; clearing needs an erase
         assign prog_val = nvm_q | sram_q;
      end else begin : g_copy
         assign prog_val = sram_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      nvm_q <= NVM_RESET_VAL;
         else if (wipe)   nvm_q <= '0;
         else if (prog_i) nvm_q <= prog_val;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         sram_q <= '0;
         else if (wipe)                      sram_q <= '0;
         else if (load_all_i)                sram_q <= nvm_q;
         else if (we_i && (idx_i == SLOT))   sram_q <= wdata_i;
      end

      assign sram_flat[gi*DATA_W +: DATA_W] = sram_q;
   end

   assign rdata_o = sram_flat[idx_i*DATA_W +: DATA_W];
endmodule

// File: rtl/nvm_shadow_ctrl.sv
`timescale 1ns/1ps
module nvm_shadow_ctrl #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int PAGES      = 4,
   parameter int PAGE_BYTES = 32,
   parameter int OP_CYCLES  = 20_000_000,
   parameter bit PROG_MERGE = 1'b1,
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h0D,
   parameter logic [ADDR_W-1:0] WIN_BASE   = 8'h40,
   parameter logic [DATA_W-1:0] BOOST_CODE = 8'h12,
   parameter logic [DATA_W-1:0] NVM_RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              boost_on_i,
   input  logic [DATA_W-1:0] boost_level_i,
   input  logic              auto_seq_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic              bus_incr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o
);
   localparam int PAGE_W = $clog2(PAGES);
   localparam int OFS_W  = $clog2(PAGE_BYTES);
   localparam int IDX_W  = PAGE_W + OFS_W;

   if (PAGES < 2 || PAGES > 4 || (PAGES & (PAGES - 1)) != 0) begin : g_bad_pages
      $error("PAGES must be 2 or 4");
   end
   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_pbytes
      $error("PAGE_BYTES must be a power of two");
   end
   if ((int'(WIN_BASE) % PAGE_BYTES) != 0) begin : g_bad_base
      $error("window base must be aligned to a page");
   end
   if (CTRL_ADDR[ADDR_W-1:OFS_W] == WIN_BASE[ADDR_W-1:OFS_W]) begin : g_bad_ctrl
      $error("control register lies inside the window");
   end

   logic              busy, load_all, erase_fire, prog_fire, ctl_wr, sram_we;
   logic [PAGE_W-1:0] page, erase_page;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] ctrl_rd, sram_rd;

   nvm_cmd_ctrl #(
      .DATA_W    (DATA_W),
      .PAGE_W    (PAGE_W),
      .OP_CYCLES (OP_CYCLES),
      .BOOST_CODE(BOOST_CODE)
   ) u_cmd (
      .clk          (clk),
      .rst_n        (rst_n),
      .active_i     (active_i),
      .boost_on_i   (boost_on_i),
      .boost_level_i(boost_level_i),
      .ctl_wr_i     (ctl_wr),
      .wdata_i      (bus_wdata_i),
      .page_o       (page),
      .busy_o       (busy),
      .load_o       (load_all),
      .erase_o      (erase_fire),
      .erase_page_o (erase_page),
      .prog_o       (prog_fire),
      .ctrl_rd_o    (ctrl_rd)
   );

   nvm_win_port #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .PAGE_W   (PAGE_W),
      .OFS_W    (OFS_W),
      .CTRL_ADDR(CTRL_ADDR),
      .WIN_BASE (WIN_BASE)
   ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (bus_wr_i),
      .rd_i      (bus_rd_i),
      .incr_i    (bus_incr_i),
      .addr_i    (bus_addr_i),
      .auto_seq_i(auto_seq_i),
      .busy_i    (busy),
      .page_i    (page),
      .ctrl_rd_i (ctrl_rd),
      .sram_rd_i (sram_rd),
      .ctl_wr_o  (ctl_wr),
      .sram_we_o (sram_we),
      .idx_o     (idx),
      .rdata_o   (bus_rdata_o)
   );

   nvm_dual_store #(
      .DATA_W       (DATA_W),
      .PAGES        (PAGES),
      .PAGE_BYTES   (PAGE_BYTES),
      .PROG_MERGE   (PROG_MERGE),
      .NVM_RESET_VAL(NVM_RESET_VAL)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_all_i  (load_all),
      .erase_i     (erase_fire),
      .erase_page_i(erase_page),
      .prog_i      (prog_fire),
      .we_i        (sram_we),
      .idx_i       (idx),
      .wdata_i     (bus_wdata_i),
      .rdata_o     (sram_rd)
   );
endmodule

// File: rtl/nvm_shadow_chk.sv
`timescale 1ns/1ps
module nvm_shadow_chk #(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] BOOST_CODE = 8'h12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              active_i,
   input logic              boost_on_i,
   input logic [DATA_W-1:0] boost_level_i,
   input logic              auto_seq_i,
   input logic              bus_rd_i,
   input logic              bus_incr_i,
   input logic [DATA_W-1:0] bus_rdata_o,
   input logic              busy,
   input logic              sram_we,
   input logic              load_all,
   input logic              erase_fire,
   input logic              prog_fire
);
   // R11
   no_wr_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sram_we);

   // R4
   no_wr_while_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      auto_seq_i |-> !sram_we);

   // R4
   seq_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && bus_incr_i && auto_seq_i) |=> (bus_rdata_o == '0));

   // R5
   no_load_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_all |-> !busy);

   // R8
   start_needs_interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(active_i && !boost_on_i && (boost_level_i == BOOST_CODE)));

   // R10
   busy_ends_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(erase_fire || prog_fire));

   // R6
   finish_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_fire || prog_fire) |-> busy);
endmodule

bind nvm_shadow_ctrl nvm_shadow_chk #(
   .DATA_W    (DATA_W),
   .BOOST_CODE(BOOST_CODE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .active_i     (active_i),
   .boost_on_i   (boost_on_i),
   .boost_level_i(boost_level_i),
   .auto_seq_i   (auto_seq_i),
   .bus_rd_i     (bus_rd_i),
   .bus_incr_i   (bus_incr_i),
   .bus_rdata_o  (bus_rdata_o),
   .busy         (busy),
   .sram_we      (sram_we),
   .load_all     (load_all),
   .erase_fire   (erase_fire),
   .prog_fire    (prog_fire)
);

// File: tb/nvm_shadow_ctrl_bench.sv
`timescale 1ns/1ps
module nvm_shadow_ctrl_bench;
   localparam int OPC = 40;
   localparam logic [7:0] CTL = 8'h0D;
   localparam logic [7:0] WIN = 8'h40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       active = 1'b1, boost_on = 1'b0, auto_seq = 1'b0;
   logic [7:0] boost_lvl = 8'h12;
   logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_incr = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;

   nvm_shadow_ctrl #(.OP_CYCLES(OPC)) u_nvm_shadow_ctrl (
      .clk(clk), .rst_n(rst_n), .active_i(active), .boost_on_i(boost_on),
      .boost_level_i(boost_lvl), .auto_seq_i(auto_seq), .bus_wr_i(bus_wr),
      .bus_rd_i(bus_rd), .bus_incr_i(bus_incr), .bus_addr_i(bus_addr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata));

   int n_chk = 0, n_bad = 0;
   logic [7:0] m_nvm [128];
   logic [7:0] m_sram[128];
   logic [1:0] m_page = 2'd0;
   logic [4:0] m_ptr = 5'd0;

   function automatic int slot(input logic [1:0] p, input logic [4:0] o);
      return int'({p, o});
   endfunction

   function automatic logic [7:0] ctl_val(input logic busy, input logic [1:0] p);
      return {busy, 5'b0, p};
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic inc);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_incr = inc;
      @(negedge clk);
      bus_wr = 1'b0; bus_incr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic inc, output logic [7:0] q);
      bus_rd = 1'b1; bus_addr = a; bus_incr = inc;
      @(negedge clk);
      bus_rd = 1'b0; bus_incr = 1'b0;
      q = bus_rdata;
   endtask

   task automatic set_page(input logic [1:0] p);
      wr(CTL, {6'b0, p}, 1'b0);
      m_page = p;
   endtask

   task automatic win_wr(input logic [4:0] o, input logic [7:0] d, input logic inc);
      logic [4:0] use_o;
      use_o = inc ? m_ptr : o;
      wr(WIN + {3'b0, o}, d, inc);
      if (!auto_seq) begin
         m_sram[slot(m_page, use_o)] = d;
         m_ptr = use_o + 5'd1;
      end
   endtask

   task automatic win_chk(input string req, input logic [4:0] o, input logic inc);
      logic [4:0] use_o;
      logic [7:0] q;
      use_o = inc ? m_ptr : o;
      rd(WIN + {3'b0, o}, inc, q);
      if (auto_seq) check(req, q, 8'h00);
      else begin
         check(req, q, m_sram[slot(m_page, use_o)]);
         m_ptr = use_o + 5'd1;
      end
   endtask

   task automatic fill_page(input logic [1:0] p);
      set_page(p);
      win_wr(5'd0, 8'($urandom), 1'b0);
      for (int i = 1; i < 32; i++) win_wr(5'd0, 8'($urandom), 1'b1);
   endtask

   task automatic page_chk(input string req, input logic [1:0] p);
      set_page(p);
      win_chk(req, 5'd0, 1'b0);
      for (int i = 1; i < 32; i++) win_chk(req, 5'd0, 1'b1);
   endtask

   task automatic m_load();
      for (int i = 0; i < 128; i++) m_sram[i] = m_nvm[i];
   endtask

   task automatic handshake(input int bitpos, input logic [1:0] p);
      wr(CTL, 8'(1 << bitpos) | {6'b0, p}, 1'b0);
      wr(CTL, {6'b0, p}, 1'b0);
      m_page = p;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] q;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 128; i++) begin m_nvm[i] = 8'h00; m_sram[i] = 8'h00; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(CTL, 1'b0, q); check("R1 ctrl", q, 8'h00);
      win_chk("R1 window", 5'd0, 1'b0);
      win_chk("R1 window", 5'd31, 1'b0);

      // R3 bursts on every page, R2 direct reads
      for (int p = 0; p < 4; p++) fill_page(2'(p));
      for (int i = 0; i < 24; i++) begin
         set_page(2'($urandom));
         win_chk("R2 direct", 5'($urandom), 1'b0);
      end

      // R2 R3 R4 random mix
      for (int i = 0; i < 300; i++) begin
         case ($urandom % 7)
            0: set_page(2'($urandom));
            1: win_wr(5'($urandom), 8'($urandom), 1'b0);
            2: win_wr(5'($urandom), 8'($urandom), 1'b1);
            3: win_chk("R2 random read", 5'($urandom), 1'b0);
            4: win_chk("R3 random incr read", 5'($urandom), 1'b1);
            5: auto_seq = ($urandom % 4) == 0;
            default: begin rd(CTL, 1'b0, q); check("R2 ctrl", q, ctl_val(1'b0, m_page)); end
         endcase
      end
      auto_seq = 1'b0;

      // R3 wrap from offset 31 to 0
      set_page(2'd1);
      win_chk("R3 wrap start", 5'd31, 1'b0);
      win_chk("R3 wrap", 5'd0, 1'b1);

      // R4 sequencer blocks the window and freezes the pointer
      win_chk("R4 setup", 5'd5, 1'b0);
      auto_seq = 1'b1;
      win_wr(5'd9, 8'h5A, 1'b0);
      win_wr(5'd0, 8'h5B, 1'b1);
      win_chk("R4 read zero", 5'd9, 1'b0);
      auto_seq = 1'b0;
      win_chk("R4 pointer kept", 5'd0, 1'b1);
      win_chk("R4 write ignored", 5'd9, 1'b0);

      // R7 R10 program with exact busy timing
      set_page(2'd0);
      handshake(4, 2'd0);
      rd(CTL, 1'b0, q); check("R10 busy after start", q, ctl_val(1'b1, 2'd0));
      repeat (OPC - 2) @(negedge clk);
      rd(CTL, 1'b0, q); check("R10 busy last cycle", q, ctl_val(1'b1, 2'd0));
      rd(CTL, 1'b0, q); check("R10 busy cleared", q, ctl_val(1'b0, 2'd0));
      for (int i = 0; i < 128; i++) m_nvm[i] = m_nvm[i] | m_sram[i];

      // scramble page 0 in SRAM only
      fill_page(2'd0);

      // R6 R11 R12 erase page 2, change page while busy
      set_page(2'd2);
      handshake(3, 2'd2);
      set_page(2'd1);
      win_wr(5'd3, 8'hA5, 1'b0);
      m_sram[slot(2'd1, 5'd3)] = m_nvm[slot(2'd1, 5'd3)];
      handshake(4, 2'd1);
      win_chk("R11 read while busy", 5'd3, 1'b0);
      repeat (OPC + 6) @(negedge clk);
      rd(CTL, 1'b0, q); check("R11 second command ignored", q, ctl_val(1'b0, 2'd1));
      for (int i = 0; i < 32; i++) begin
         m_nvm[slot(2'd2, 5'(i))] = 8'h00;
         m_sram[slot(2'd2, 5'(i))] = 8'h00;
      end
      win_chk("R11 write ignored", 5'd3, 1'b0);
      page_chk("R6 R12 sram page erased", 2'd2);
      page_chk("R6 other page kept", 2'd0);

      // R5 load command restores SRAM from NVM
      handshake(2, 2'd0);
      m_load();
      rd(CTL, 1'b0, q); check("R5 ctrl after load", q, ctl_val(1'b0, 2'd0));
      for (int p = 0; p < 4; p++) page_chk("R5 R6 R11 load", 2'(p));

      // R7 merge: program new data over old without erase
      fill_page(2'd3);
      handshake(4, 2'd3);
      repeat (OPC + 4) @(negedge clk);
      for (int i = 0; i < 128; i++) m_nvm[i] = m_nvm[i] | m_sram[i];
      fill_page(2'd3);
      handshake(2, 2'd3);
      m_load();
      page_chk("R7 or merge", 2'd3);

      // R8 three interlock violations
      for (int v = 0; v < 3; v++) begin
         if (v == 0) boost_on = 1'b1;
         if (v == 1) boost_lvl = 8'h13;
         if (v == 2) active = 1'b0;
         handshake(3, 2'd0);
         rd(CTL, 1'b0, q); check("R8 refused", q, ctl_val(1'b0, 2'd0));
         boost_on = 1'b0; boost_lvl = 8'h12; active = 1'b1;
         @(negedge clk);
         if (v == 2) m_load();
         repeat (OPC + 4) @(negedge clk);
         handshake(2, 2'd0);
         m_load();
         page_chk("R8 page intact", 2'd0);
      end

      // R9 both bits at once
      wr(CTL, 8'h18, 1'b0);
      rd(CTL, 1'b0, q); check("R9 both rejected", q, 8'h00);
      wr(CTL, 8'h08, 1'b0);
      wr(CTL, 8'h18, 1'b0);
      rd(CTL, 1'b0, q); check("R9 bits kept", q, 8'h08);
      boost_on = 1'b1;
      wr(CTL, 8'h00, 1'b0);
      boost_on = 1'b0;
      rd(CTL, 1'b0, q); check("R9 no operation", q, 8'h00);
      page_chk("R9 data intact", 2'd0);

      // R5 active rising edge reloads SRAM
      fill_page(2'd1);
      active = 1'b0;
      repeat (3) @(negedge clk);
      active = 1'b1;
      repeat (2) @(negedge clk);
      m_load();
      page_chk("R5 active edge", 2'd1);

      finish_run();
   end
endmodule